// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address. It walks a two-level translation table held in memory. A requester presents a virtual address and the base of the first-level table, then waits for a single response. The block fetches the first-level descriptor through a read port with a valid/ready request side and a response side that can arrive any number of cycles later. A 1MB section ends the walk after that one read. A pointer to a second-level table makes the block fetch a second descriptor, which can describe a 4KB page.

The response carries the physical address and the attribute bits of the last descriptor read. It also gives that descriptor's raw type code, the level the walk ended at, and an execute-never flag. Two error flags are kept apart: a fault flag for unmapped entries and an unsupported flag for 64KB large-page descriptors. The walker holds one translation at a time and shows this on a busy output.

The walk moves through these states. IDLE leads to L1_ISSUE on an accepted request. L1_ISSUE leads to L1_WAIT when the read handshake completes. L1_WAIT leads to L2_ISSUE when the returned descriptor is a table pointer, and to REPLY otherwise. L2_ISSUE leads to L2_WAIT when the read handshake completes. L2_WAIT leads to REPLY when the data returns. REPLY always goes back to IDLE.

Top module: `ptw_walker`

## Requirements
- R1: After reset, busy, resp_valid and mem_rd_valid are all low.
- R2: A request is taken when req_valid is high and busy is low. busy is high from the next cycle until the cycle after the single-cycle resp_valid pulse. req_valid is ignored while busy is high: it starts no further memory read and no further response.
- R3: The first read goes to address req_tbase + 4 × VA[31:20].
- R4: While mem_rd_valid is high and mem_rd_ready is low, mem_rd_valid stays high and mem_rd_addr holds its value. Response data is accepted whenever mem_rsp_valid is high, however many cycles later that is.
- R5: A first-level type code (bits [1:0]) of 00 or 11 ends the walk with resp_fault high, resp_level 0 and resp_paddr zero, after exactly one read.
- R6: A first-level type code of 10 (section) ends the walk after exactly one read. The physical address is descriptor[31:20] joined with VA[19:0], and resp_level is 0.
- R7: A first-level type code of 01 causes a second read at address descriptor[31:10] joined with VA[19:12] and 2'b00.
- R8: A second-level type code of 10 or 11 gives a physical address of descriptor[31:12] joined with VA[11:0] and resp_level 1. resp_xn is 1 only for type 11.
- R9: A second-level type code of 00 ends the walk with resp_fault high, resp_level 1 and resp_paddr zero.
- R10: A second-level type code of 01 (64KB page) ends the walk with resp_unsup high, resp_fault low and resp_paddr zero.
- R11: On every response, resp_attr equals bits [11:2] of the last descriptor read and resp_dtype equals its bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_tbase | input | 32 | First-level table base address |
| busy | output | 1 | A walk is in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | 32 | Translated physical address (zero on error) |
| resp_attr | output | 10 | Bits [11:2] of the last descriptor read |
| resp_dtype | output | 2 | Type code of the last descriptor read |
| resp_level | output | 1 | 0: walk ended at first level; 1: at second level |
| resp_xn | output | 1 | Execute-never small page |
| resp_fault | output | 1 | Translation fault |
| resp_unsup | output | 1 | Large-page descriptor found (unsupported) |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor returned by memory |

## Verification
The bench counts memory reads and logs their addresses. A section or first-level fault that wrongly issued a second fetch shows up as two reads. A table pointer that was taken for a section shows up as one. First-level types 11 and 01 are both used, so a decoder that treats 11 as a table pointer or a section is caught by its read count or its fault flag. Small pages of both second-level types are checked to catch an address splice at the wrong bit boundary and a lost execute-never flag. A large page is checked to catch one reported as a plain fault. Slow ready and long latency are applied while req_valid stays high during the walk, to catch a request captured twice and an address that drifts during a stall.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_ISSUE,
        ST_L1_WAIT,
        ST_L2_ISSUE,
        ST_L2_WAIT,
        ST_REPLY
    } walk_state_e;

    typedef enum logic [2:0] {
        DK_FAULT,
        DK_TABLE,
        DK_SECTION,
        DK_SMALL,
        DK_LARGE
    } desc_kind_e;

    // two-bit type codes carried in descriptor bits [1:0]
    localparam logic [1:0] TC_00 = 2'b00;
    localparam logic [1:0] TC_01 = 2'b01;
    localparam logic [1:0] TC_10 = 2'b10;
    localparam logic [1:0] TC_11 = 2'b11;

endpackage

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
    import ptw_pkg::*;
#(
    parameter int LEVEL = 1
) (
    input  logic [1:0] dtype,
    output desc_kind_e kind
);

    generate
        if (LEVEL == 1) begin : g_first
            always_comb begin
                unique case (dtype)
                    TC_01:   kind = DK_TABLE;
                    TC_10:   kind = DK_SECTION;
                    default: kind = DK_FAULT;   // 00 and 11
                endcase
            end
        end else begin : g_second
            always_comb begin
                unique case (dtype)
                    TC_01:   kind = DK_LARGE;
                    TC_10,
                    TC_11:   kind = DK_SMALL;
                    default: kind = DK_FAULT;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int ADDR_W   = 32,
    parameter int L1_IDX_W = 12,
    parameter int L2_IDX_W = 8,
    localparam int L2B_W   = ADDR_W - L2_IDX_W - 2
) (
    input  logic [ADDR_W-1:0]   tbase,
    input  logic [L1_IDX_W-1:0] l1_idx,
    input  logic [L2_IDX_W-1:0] l2_idx,
    input  logic [L2B_W-1:0]    l2_base,
    output logic [ADDR_W-1:0]   l1_addr,
    output logic [ADDR_W-1:0]   l2_addr
);

    logic [ADDR_W-1:0] l1_off;

    always_comb begin
        l1_off  = ADDR_W'(l1_idx) << 2;
        l1_addr = tbase + l1_off;
        l2_addr = {l2_base, l2_idx, 2'b00};
    end

endmodule

// File: rtl/ptw_result_pack.sv
module ptw_result_pack
    import ptw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int L2_IDX_W   = 8,
    localparam int SECT_SHIFT = PAGE_SHIFT + L2_IDX_W,
    localparam int ATTR_W     = PAGE_SHIFT - 2
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-1:0] desc,
    input  desc_kind_e        kind,
    input  logic              level,
    output logic [ADDR_W-1:0] paddr,
    output logic [ATTR_W-1:0] attr,
    output logic [1:0]        dtype,
    output logic              xn,
    output logic              fault,
    output logic              unsup
);

    always_comb begin
        unique case (kind)
            DK_SECTION: paddr = {desc[ADDR_W-1:SECT_SHIFT], vaddr[SECT_SHIFT-1:0]};
            DK_SMALL:   paddr = {desc[ADDR_W-1:PAGE_SHIFT], vaddr[PAGE_SHIFT-1:0]};
            default:    paddr = '0;
        endcase
        attr  = desc[PAGE_SHIFT-1:2];
        dtype = desc[1:0];
        xn    = level && (kind == DK_SMALL) && (desc[1:0] == TC_11);
        fault = (kind == DK_FAULT);
        unsup = (kind == DK_LARGE);
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int L1_IDX_W   = 12,
    parameter int L2_IDX_W   = 8,
    parameter int PAGE_SHIFT = 12,
    localparam int SECT_SHIFT = PAGE_SHIFT + L2_IDX_W,
    localparam int ATTR_W     = PAGE_SHIFT - 2,
    localparam int L2B_W      = ADDR_W - L2_IDX_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] req_tbase,
    output logic              busy,
    output logic              resp_valid,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic [ATTR_W-1:0] resp_attr,
    output logic [1:0]        resp_dtype,
    output logic              resp_level,
    output logic              resp_xn,
    output logic              resp_fault,
    output logic              resp_unsup,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data
);

    walk_state_e state_q, state_d;

    logic [ADDR_W-1:0] va_q;
    logic [ADDR_W-1:0] tbase_q;
    logic [L2B_W-1:0]  l2base_q;

    logic [ADDR_W-1:0] paddr_q;
    logic [ATTR_W-1:0] attr_q;
    logic [1:0]        dtype_q;
    logic              level_q, xn_q, fault_q, unsup_q;

    logic [ADDR_W-1:0] l1_addr_w, l2_addr_w;
    desc_kind_e        kind_w [2];
    desc_kind_e        kind_sel;
    logic              lvl_sel;

    logic [ADDR_W-1:0] pk_paddr;
    logic [ATTR_W-1:0] pk_attr;
    logic [1:0]        pk_dtype;
    logic              pk_xn, pk_fault, pk_unsup;

    logic accept, l1_done, l2_done, l1_is_table;

    // one descriptor decoder per table level
    generate
        for (genvar g = 0; g < 2; g++) begin : g_dec
            ptw_desc_decode #(.LEVEL(g + 1)) u_dec (
                .dtype (mem_rsp_data[1:0]),
                .kind  (kind_w[g])
            );
        end
    endgenerate

    ptw_addr_gen #(
        .ADDR_W   (ADDR_W),
        .L1_IDX_W (L1_IDX_W),
        .L2_IDX_W (L2_IDX_W)
    ) u_addr (
        .tbase   (tbase_q),
        .l1_idx  (va_q[ADDR_W-1 -: L1_IDX_W]),
        .l2_idx  (va_q[SECT_SHIFT-1:PAGE_SHIFT]),
        .l2_base (l2base_q),
        .l1_addr (l1_addr_w),
        .l2_addr (l2_addr_w)
    );

    assign lvl_sel  = (state_q == ST_L2_WAIT);
    assign kind_sel = lvl_sel ? kind_w[1] : kind_w[0];

    ptw_result_pack #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .L2_IDX_W   (L2_IDX_W)
    ) u_pack (
        .vaddr (va_q),
        .desc  (mem_rsp_data),
        .kind  (kind_sel),
        .level (lvl_sel),
        .paddr (pk_paddr),
        .attr  (pk_attr),
        .dtype (pk_dtype),
        .xn    (pk_xn),
        .fault (pk_fault),
        .unsup (pk_unsup)
    );

    assign accept      = (state_q == ST_IDLE) && req_valid;
    assign l1_done     = (state_q == ST_L1_WAIT) && mem_rsp_valid;
    assign l2_done     = (state_q == ST_L2_WAIT) && mem_rsp_valid;
    assign l1_is_table = (kind_w[0] == DK_TABLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid)     state_d = ST_L1_ISSUE;
            ST_L1_ISSUE: if (mem_rd_ready)  state_d = ST_L1_WAIT;
            ST_L1_WAIT:  if (mem_rsp_valid) state_d = l1_is_table ? ST_L2_ISSUE : ST_REPLY;
            ST_L2_ISSUE: if (mem_rd_ready)  state_d = ST_L2_WAIT;
            ST_L2_WAIT:  if (mem_rsp_valid) state_d = ST_REPLY;
            ST_REPLY:                       state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q     <= '0;
            tbase_q  <= '0;
            l2base_q <= '0;
        end else begin
            if (accept) begin
                va_q    <= req_vaddr;
                tbase_q <= req_tbase;
            end
            if (l1_done && l1_is_table)
                l2base_q <= mem_rsp_data[ADDR_W-1:L2_IDX_W+2];
        end
    end

    // result capture at the terminating descriptor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paddr_q <= '0;
            attr_q  <= '0;
            dtype_q <= '0;
            level_q <= 1'b0;
            xn_q    <= 1'b0;
            fault_q <= 1'b0;
            unsup_q <= 1'b0;
        end else if ((l1_done && !l1_is_table) || l2_done) begin
            paddr_q <= pk_paddr;
            attr_q  <= pk_attr;
            dtype_q <= pk_dtype;
            level_q <= lvl_sel;
            xn_q    <= pk_xn;
            fault_q <= pk_fault;
            unsup_q <= pk_unsup;
        end
    end

    // outputs
    always_comb begin
        busy         = (state_q != ST_IDLE);
        resp_valid   = (state_q == ST_REPLY);
        mem_rd_valid = (state_q == ST_L1_ISSUE) || (state_q == ST_L2_ISSUE);
        mem_rd_addr  = (state_q == ST_L2_ISSUE) ? l2_addr_w : l1_addr_w;
        resp_paddr   = paddr_q;
        resp_attr    = attr_q;
        resp_dtype   = dtype_q;
        resp_level   = level_q;
        resp_xn      = xn_q;
        resp_fault   = fault_q;
        resp_unsup   = unsup_q;
    end

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int ADDR_W = 32,
    parameter int ATTR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              resp_valid,
    input logic [ADDR_W-1:0] resp_paddr,
    input logic [ATTR_W-1:0] resp_attr,
    input logic [1:0]        resp_dtype,
    input logic              resp_level,
    input logic              resp_xn,
    input logic              resp_fault,
    input logic              resp_unsup,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [ADDR_W-1:0] mem_rd_addr
);

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    assert_reply_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && !busy));

    assert_idle_noread_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_valid);

    assert_read_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    assert_error_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (resp_fault || resp_unsup)) |-> (resp_paddr == '0));

    assert_unsup_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_unsup) |-> (!resp_fault && resp_level && resp_dtype == 2'b01));

    assert_xn_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_xn) |-> (resp_level && resp_dtype == 2'b11 && !resp_fault));

    assert_section_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_level && resp_dtype == 2'b10) |-> (!resp_fault && !resp_unsup && resp_attr == resp_attr));

endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .busy         (busy),
    .resp_valid   (resp_valid),
    .resp_paddr   (resp_paddr),
    .resp_attr    (resp_attr),
    .resp_dtype   (resp_dtype),
    .resp_level   (resp_level),
    .resp_xn      (resp_xn),
    .resp_fault   (resp_fault),
    .resp_unsup   (resp_unsup),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;

    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_tbase = '0;
    logic        busy, resp_valid;
    logic [31:0] resp_paddr;
    logic [9:0]  resp_attr;
    logic [1:0]  resp_dtype;
    logic        resp_level, resp_xn, resp_fault, resp_unsup;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    always #(CLK_NS/2) clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_tbase(req_tbase), .busy(busy), .resp_valid(resp_valid),
        .resp_paddr(resp_paddr), .resp_attr(resp_attr), .resp_dtype(resp_dtype),
        .resp_level(resp_level), .resp_xn(resp_xn), .resp_fault(resp_fault),
        .resp_unsup(resp_unsup), .mem_rd_valid(mem_rd_valid),
        .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // sparse descriptor memory; missing words read as zero (fault type)
    logic [31:0] mem [logic [31:0]];
    int          rd_count = 0;
    logic [31:0] addr_log [4];
    int          lat_cfg = 0;
    int          stall_cfg = 0;

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // memory responder: decisions at the falling edge
    initial begin
        bit          pend = 0;
        int          cnt = 0;
        int          stall_left = 0;
        logic [31:0] pa = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                mem_rd_ready = 1'b0;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_read(pa);
                    pend = 0;
                end else cnt--;
            end else if (!mem_rd_valid) begin
                mem_rd_ready = 1'b0;
                stall_left = stall_cfg;
            end else if (stall_left > 0) begin
                mem_rd_ready = 1'b0;
                stall_left--;
            end else begin
                mem_rd_ready = 1'b1;
                pend = 1;
                cnt  = lat_cfg;
                pa   = mem_rd_addr;
                if (rd_count < 4) addr_log[rd_count] = mem_rd_addr;
                rd_count++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [31:0] r_paddr;
    logic [9:0]  r_attr;
    logic [1:0]  r_dtype;
    logic        r_level, r_xn, r_fault, r_unsup;

    task automatic wait_resp(input string tag);
        bit got = 0;
        for (int i = 0; i < 400 && !got; i++) begin
            if (resp_valid) begin
                got = 1;
                r_paddr = resp_paddr; r_attr = resp_attr; r_dtype = resp_dtype;
                r_level = resp_level; r_xn = resp_xn; r_fault = resp_fault;
                r_unsup = resp_unsup;
            end else @(negedge clk);
        end
        check(got, {tag, " response arrives (R2)"}, 32'(got), 32'd1);
        @(negedge clk);
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] tb, input string tag);
        rd_count = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_tbase = tb;
        @(negedge clk);
        req_valid = 1'b0;
        wait_resp(tag);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy,         "R1 busy after reset",  32'(busy), 0);
        check(!resp_valid,   "R1 resp_valid after reset", 32'(resp_valid), 0);
        check(!mem_rd_valid, "R1 mem_rd_valid after reset", 32'(mem_rd_valid), 0);
    endtask

    task automatic t_section();
        walk(32'h1234_5678, 32'h0004_0000, "section");
        check(rd_count == 1,             "R6 section read count", rd_count, 1);
        check(addr_log[0] == 32'h0004_048C, "R3 section L1 address", addr_log[0], 32'h0004_048C);
        check(r_paddr == 32'hABC4_5678,  "R6 section paddr", r_paddr, 32'hABC4_5678);
        check(!r_fault && !r_unsup && !r_level, "R6 section flags", {r_fault, r_unsup, r_level}, 0);
        check(r_attr == 10'h303,         "R11 section attr", 32'(r_attr), 32'h303);
        check(r_dtype == 2'b10,          "R11 section dtype", 32'(r_dtype), 2);
    endtask

    task automatic t_l1_fault();
        walk(32'hFFF0_0000, 32'h0004_4000, "l1 fault");
        check(addr_log[0] == 32'h0004_7FFC, "R3 L1 address with offset base", addr_log[0], 32'h0004_7FFC);
        check(rd_count == 1,    "R5 type00 read count", rd_count, 1);
        check(r_fault && !r_level && r_paddr == 0, "R5 type00 fault", {r_fault, r_level, r_paddr[29:0]}, 32'h8000_0000);
        check(r_dtype == 2'b00, "R11 type00 dtype", 32'(r_dtype), 0);
    endtask

    task automatic t_l1_type3();
        walk(32'h0020_0ABC, 32'h0004_0000, "l1 type11");
        check(rd_count == 1,    "R5 type11 read count", rd_count, 1);
        check(r_fault && !r_unsup && r_paddr == 0, "R5 type11 fault", {r_fault, r_unsup, r_paddr[29:0]}, 32'h8000_0000);
        check(r_dtype == 2'b11, "R11 type11 dtype", 32'(r_dtype), 3);
        check(r_attr == 10'h000, "R11 type11 attr", 32'(r_attr), 0);
    endtask

    task automatic t_small(input int lat, input int stall);
        lat_cfg = lat; stall_cfg = stall;
        walk(32'h3007_A123, 32'h0004_0000, "small");
        check(rd_count == 2,                "R7 small read count", rd_count, 2);
        check(addr_log[0] == 32'h0004_0C00, "R3 table L1 address", addr_log[0], 32'h0004_0C00);
        check(addr_log[1] == 32'h0008_05E8, "R7 L2 address", addr_log[1], 32'h0008_05E8);
        check(r_paddr == 32'hCAFE_B123,     "R8 small paddr", r_paddr, 32'hCAFE_B123);
        check(r_level && !r_xn && !r_fault, "R8 small flags", {r_level, r_xn, r_fault}, 32'h4);
        check(r_attr == 10'h117,            "R11 small attr", 32'(r_attr), 32'h117);
        lat_cfg = 0; stall_cfg = 0;
    endtask

    task automatic t_small_xn();
        walk(32'h3001_0FFF, 32'h0004_0000, "small xn");
        check(addr_log[1] == 32'h0008_0440, "R7 xn L2 address", addr_log[1], 32'h0008_0440);
        check(r_paddr == 32'h1357_9FFF,     "R8 xn paddr", r_paddr, 32'h1357_9FFF);
        check(r_xn && r_level,              "R8 xn flag", {r_xn, r_level}, 3);
        check(r_attr == 10'h3FC && r_dtype == 2'b11, "R11 xn attr/dtype", {r_attr, r_dtype}, {10'h3FC, 2'b11});
    endtask

    task automatic t_l2_fault();
        walk(32'h3002_0000, 32'h0004_0000, "l2 fault");
        check(rd_count == 2, "R9 read count", rd_count, 2);
        check(r_fault && r_level && !r_unsup && r_paddr == 0, "R9 l2 fault",
              {r_fault, r_level, r_unsup, r_paddr[28:0]}, 32'hC000_0000);
    endtask

    task automatic t_large();
        walk(32'h3003_0000, 32'h0004_0000, "large");
        check(r_unsup && !r_fault,  "R10 unsupported flag", {r_unsup, r_fault}, 2);
        check(r_paddr == 0,         "R10 paddr zero", r_paddr, 0);
        check(r_dtype == 2'b01 && r_level, "R11 large dtype/level", {r_dtype, r_level}, 3);
    endtask

    task automatic t_busy_ignore();
        bit busy_ok = 1;
        lat_cfg = 5; stall_cfg = 2;
        rd_count = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h3007_A123; req_tbase = 32'h0004_0000;
        @(negedge clk);
        req_vaddr = 32'h1234_5678;
        for (int i = 0; i < 3; i++) begin
            if (!busy) busy_ok = 0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(busy_ok, "R2 busy while request held", 32'(busy_ok), 1);
        wait_resp("busy ignore");
        check(r_paddr == 32'hCAFE_B123, "R2 first request kept", r_paddr, 32'hCAFE_B123);
        check(rd_count == 2, "R2 extra request ignored", rd_count, 2);
        repeat (6) @(negedge clk);
        check(rd_count == 2 && !busy, "R2 no later walk", {rd_count[30:0], busy}, 32'd4);
        lat_cfg = 0; stall_cfg = 0;
    endtask

    initial begin
        mem[32'h0004_048C] = 32'hABC0_0C0E;   // section
        mem[32'h0004_0008] = 32'h5555_5003;   // first-level type 11
        mem[32'h0004_0C00] = 32'h0008_0401;   // table pointer
        mem[32'h0008_05E8] = 32'hCAFE_B45E;   // small page
        mem[32'h0008_0440] = 32'h1357_9FF3;   // small page, execute-never
        mem[32'h0008_04C0] = 32'h7777_0001;   // large page

        t_reset();
        t_section();
        t_l1_fault();
        t_l1_type3();
        t_small(0, 0);
        t_small(7, 3);
        t_small_xn();
        t_l2_fault();
        t_large();
        t_busy_ignore();

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule